// File: doc/BRIEF.md
# Signed Word Encoding Converter

The converter takes an N-bit signed word and re-expresses the same numeric value in another signed encoding. It handles sign-and-magnitude, ones' complement and twos' complement. A data word arrives with a source-format code and a destination-format code, and a valid strobe qualifies it. One clock later the converted word appears on a registered output, together with an output valid flag. An unrepresentable flag is raised when the value has no equivalent in the destination encoding.

A negate mode gives the arithmetic negation of the input. The result stays in the source encoding, and the destination code is ignored in this mode. Zero handling follows fixed rules. Both forms of zero in sign-and-magnitude and ones' complement are accepted. Twos' complement has one extra negative value, and the block detects it wherever it cannot be carried over.

Top module: `signfmt_conv`

## Requirements
- R1: While rst_ni is low, and after it is released, `valid_o`, `unrep_o` and `data_o` are all zero.
- R2: `valid_o` equals the value `valid_i` had one clock earlier. When `valid_i` is low, `data_o` keeps its previous value and `unrep_o` is zero after the next edge.
- R3: Format codes are 0 for sign-and-magnitude, 1 for ones' complement, 2 for twos' complement, and 3 also for twos' complement. In every format the MSB is the sign, with 1 meaning negative. A non-negative value converts to the same bit pattern in every format.
- R4: A nonzero negative value converts to the bit pattern that encodes the same value in the destination format. In sign-and-magnitude that pattern is the MSB at 1 with the magnitude below it. In ones' complement it is all bits of the magnitude inverted. In twos' complement it is inverted plus one.
- R5: Converting between different formats always yields a zero word for a zero value. Negative zero (MSB only, or all ones in ones' complement) becomes all zeros.
- R6: Converting the most-negative twos' complement word (MSB only) to sign-and-magnitude or ones' complement outputs all zeros and raises `unrep_o`.
- R7: When the source and destination codes name the same format, the word passes through unchanged, negative zero included, and `unrep_o` stays low.
- R8: In negate mode, sign-and-magnitude flips only the MSB and ones' complement inverts every bit.
- R9: In negate mode, twos' complement inverts every bit and adds one. The most-negative word is returned unchanged with `unrep_o` raised.
- R10: `unrep_o` is only ever high together with `valid_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Input word qualifier |
| data_i | input | W | Input word |
| src_fmt_i | input | 2 | Source encoding code |
| dst_fmt_i | input | 2 | Destination encoding code |
| negate_i | input | 1 | Negate within the source encoding |
| data_o | output | W | Registered result word |
| valid_o | output | 1 | Result valid, one cycle after valid_i |
| unrep_o | output | 1 | Value has no equivalent in the result encoding |

## Verification
The bench builds the converter with W = 4, so all sixteen words can be driven through every pairing of source and destination codes, both with and without negate mode. At that width the two negative zeros, the lone most-negative twos' complement word, and the largest positive and negative magnitudes are all inside the sweep. The expected words come from decoding each input to an integer and encoding that integer again. A few extra steps cover format code 3 and the hold behaviour while the strobe is low.

// File: rtl/signfmt_pkg.sv
package signfmt_pkg;
  typedef enum logic [1:0] {
    FMT_SM  = 2'd0,
    FMT_OC  = 2'd1,
    FMT_TC  = 2'd2,
    FMT_TC3 = 2'd3
  } fmt_e;

  function automatic fmt_e norm_fmt(logic [1:0] code);
    return (code == 2'd3) ? FMT_TC : fmt_e'(code);
  endfunction
endpackage

// File: rtl/signfmt_decode.sv
module signfmt_decode
  import signfmt_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] word_i,
  input  fmt_e         fmt_i,
  output logic         neg_o,
  output logic [W-1:0] mag_o   // W bits: holds 2^(W-1) for most-negative twos' value
);
  logic [W-1:0] low_ext;
  assign low_ext = {1'b0, word_i[W-2:0]};

  always_comb begin
    unique case (fmt_i)
      FMT_SM:  mag_o = low_ext;
      FMT_OC:  mag_o = word_i[W-1] ? {1'b0, ~word_i[W-2:0]} : low_ext;
      default: mag_o = word_i[W-1] ? (~word_i + 1'b1) : word_i;
    endcase
    neg_o = word_i[W-1] && (mag_o != '0);
  end
endmodule

// File: rtl/signfmt_encode.sv
module signfmt_encode
  import signfmt_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         neg_i,
  input  logic [W-1:0] mag_i,
  input  fmt_e         fmt_i,
  output logic [W-1:0] word_o,
  output logic         unrep_o
);
  logic too_big;
  assign too_big = mag_i[W-1];

  always_comb begin
    unrep_o = 1'b0;
    unique case (fmt_i)
      FMT_SM: begin
        unrep_o = too_big;
        word_o  = too_big ? '0 : {neg_i, mag_i[W-2:0]};
      end
      FMT_OC: begin
        unrep_o = too_big;
        word_o  = too_big ? '0 : (neg_i ? ~mag_i : mag_i);
      end
      default: word_o = neg_i ? (~mag_i + 1'b1) : mag_i;
    endcase
  end
endmodule

// File: rtl/signfmt_conv.sv
module signfmt_conv
  import signfmt_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [W-1:0] data_i,
  input  logic [1:0]   src_fmt_i,
  input  logic [1:0]   dst_fmt_i,
  input  logic         negate_i,
  output logic [W-1:0] data_o,
  output logic         valid_o,
  output logic         unrep_o
);
  localparam logic [W-1:0] MinWord = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] AllOne  = '1;

  fmt_e         src_f, dst_f;
  logic         dec_neg;
  logic [W-1:0] dec_mag, enc_word, neg_word, nxt_word;
  logic         enc_unrep, nxt_unrep, same_fmt;

  assign src_f    = norm_fmt(src_fmt_i);
  assign dst_f    = norm_fmt(dst_fmt_i);
  assign same_fmt = (src_f == dst_f);

  signfmt_decode #(.W(W)) u_dec (
    .word_i(data_i), .fmt_i(src_f), .neg_o(dec_neg), .mag_o(dec_mag)
  );

  signfmt_encode #(.W(W)) u_enc (
    .neg_i(dec_neg), .mag_i(dec_mag), .fmt_i(dst_f),
    .word_o(enc_word), .unrep_o(enc_unrep)
  );

  always_comb begin
    unique case (src_f)
      FMT_SM:  neg_word = data_i ^ MinWord;
      FMT_OC:  neg_word = data_i ^ AllOne;
      default: neg_word = ~data_i + 1'b1;  // MinWord maps to itself
    endcase
  end

  always_comb begin
    if (negate_i) begin
      nxt_word  = neg_word;
      nxt_unrep = (src_f == FMT_TC) && (data_i == MinWord);
    end else if (same_fmt) begin
      nxt_word  = data_i;
      nxt_unrep = 1'b0;
    end else begin
      nxt_word  = enc_word;
      nxt_unrep = enc_unrep;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o  <= '0;
      valid_o <= 1'b0;
      unrep_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      unrep_o <= valid_i && nxt_unrep;
      if (valid_i) data_o <= nxt_word;
    end
  end

  // R2
  valid_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  // R2
  valid_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && $stable(data_o)));
  // R10
  unrep_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unrep_o |-> valid_o);
  // R6
  unrep_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !negate_i && !same_fmt) |=> (!unrep_o || data_o == '0));
  // R5
  no_negzero_sm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !negate_i && !same_fmt && dst_f == FMT_SM) |=> (data_o != MinWord));
  // R7
  same_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !negate_i && same_fmt) |=> (!unrep_o && data_o == $past(data_i)));
  // R6
  big_mag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_mag[W-1] |-> (src_f == FMT_TC && data_i == MinWord));
endmodule

// File: tb/tb_signfmt_conv.sv
module tb_signfmt_conv;
  localparam int W = 4;
  localparam time ClkPeriod = 10ns;

  logic clk = 1'b0, rst_ni = 1'b0, valid_i = 1'b0, negate_i = 1'b0;
  logic [W-1:0] data_i = '0;
  logic [1:0] src_fmt_i = '0, dst_fmt_i = '0;
  logic [W-1:0] data_o;
  logic valid_o, unrep_o;
  int n_chk = 0, n_fail = 0;

  always #(ClkPeriod/2) clk = ~clk;

  signfmt_conv #(.W(W)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .data_i(data_i),
    .src_fmt_i(src_fmt_i), .dst_fmt_i(dst_fmt_i), .negate_i(negate_i),
    .data_o(data_o), .valid_o(valid_o), .unrep_o(unrep_o)
  );

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (data %0d src %0d dst %0d neg %0b)",
               req, act, exp, data_i, src_fmt_i, dst_fmt_i, negate_i);
    end
  endtask

  // integer value of a 4-bit word; fmt 0 SM, 1 OC, else TC
  function automatic int val_of(int w, int f);
    if (f == 0) return (w >= 8) ? -(w - 8) : w;
    if (f == 1) return (w >= 8) ? -((~w) & 15) : w;
    return (w >= 8) ? w - 16 : w;
  endfunction

  function automatic void expect_of(int w, int s, int d, bit ng,
                                    output int ew, output int eu);
    int sf = (s == 3) ? 2 : s;
    int df = (d == 3) ? 2 : d;
    int v;
    eu = 0;
    if (ng) begin
      if (sf == 0) ew = w ^ 8;
      else if (sf == 1) ew = w ^ 15;
      else begin ew = (-w) & 15; eu = (w == 8); end
      return;
    end
    if (sf == df) begin ew = w; return; end
    v = val_of(w, sf);
    if (df == 2) ew = v & 15;
    else if (v < -7) begin ew = 0; eu = 1; end
    else if (v >= 0) ew = v;
    else if (df == 0) ew = 8 | (-v);
    else ew = (~(-v)) & 15;
  endfunction

  function automatic string tag(int w, int s, int d, bit ng);
    int sf = (s == 3) ? 2 : s;
    int df = (d == 3) ? 2 : d;
    int v = val_of(w, sf);
    if (s == 3 || d == 3) return "R3";
    if (ng) return (sf == 2) ? "R9" : "R8";
    if (sf == df) return "R7";
    if (sf == 2 && w == 8) return "R6";
    if (v == 0) return "R5";
    if (v < 0) return "R4";
    return "R3";
  endfunction

  task automatic run_one(int w, int s, int d, bit ng);
    int ew, eu;
    string t;
    @(negedge clk);
    valid_i = 1'b1; data_i = W'(w); src_fmt_i = 2'(s); dst_fmt_i = 2'(d); negate_i = ng;
    expect_of(w, s, d, ng, ew, eu);
    t = tag(w, s, d, ng);
    @(negedge clk);
    check(t, int'(data_o), ew);
    check((t == "R6" || t == "R9") ? t : "R10", int'(unrep_o), eu);
    check("R2", int'(valid_o), 1);
  endtask

  initial begin
    #(ClkPeriod * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(ClkPeriod * 2);
    // R1 during reset
    check("R1", int'(data_o), 0);
    check("R1", int'(valid_o), 0);
    check("R1", int'(unrep_o), 0);
    @(negedge clk); rst_ni = 1'b1;
    @(negedge clk);
    check("R1", int'(data_o), 0);
    check("R1", int'(unrep_o), 0);

    for (int s = 0; s < 3; s++)
      for (int d = 0; d < 3; d++)
        for (int ng = 0; ng < 2; ng++)
          for (int w = 0; w < 16; w++)
            run_one(w, s, d, ng[0]);

    // R3 code 3 acts as twos' complement
    run_one(8, 3, 0, 1'b0);
    run_one(13, 0, 3, 1'b0);
    run_one(11, 3, 2, 1'b0);
    run_one(8, 3, 3, 1'b1);

    // R2 hold while strobe low, after a flagged result
    run_one(8, 2, 1, 1'b0);
    run_one(5, 1, 0, 1'b0);
    @(negedge clk);
    valid_i = 1'b0; data_i = 4'd12; src_fmt_i = 2'd2; dst_fmt_i = 2'd0;
    @(negedge clk);
    check("R2", int'(valid_o), 0);
    check("R2", int'(data_o), 5);
    check("R10", int'(unrep_o), 0);
    run_one(8, 2, 0, 1'b0);
    @(negedge clk);
    valid_i = 1'b0;
    @(negedge clk);
    check("R10", int'(unrep_o), 0);
    check("R2", int'(data_o), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule